// File: doc/BRIEF.md
# Programmable Panel Control Pulse Generator

This block is one channel of the control-output bank in an LCD panel timing controller. It watches the controller's running line and pixel counters and drives a single control line toward the row or column drivers. Four timing values place a rectangular window in the frame. A horizontal span selects pixels within each line, and a vertical span selects lines within the frame. The intersection of the two becomes an internal pulse. Depending on the values programmed, the output is a steady level, one pulse per line, or one long pulse per frame.

An 8-bit control byte shapes the final output. One bit inverts the polarity. One bit turns the output into a reversal signal, which flips on every new pulse. Two bits merge the channel with the output of its lower-numbered neighbour. Two more bits hold the output inactive until a chosen number of frame starts have occurred after configuration completes. Channels are chained: each one's output feeds the neighbour input of the next. The first channel ties that input to 0.

Top module: `gpo_chan`

## Requirements
- R1: The horizontal span is active while `pixCnt` >= `hStart` and `pixCnt` < `hStart` + `hDur`. The sum is formed one bit wider than the counters, so it never wraps. When `hDur` = 0, the horizontal span is always active.
- R2: The vertical span is active while `lineCnt` >= `vStart` and `lineCnt` < `vStart` + `vDur`. The sum is formed one bit wider than the counters. When `vDur` = 0, the vertical span is always active.
- R3: The internal pulse is the AND of both spans. `gpoOut` is registered: it reflects the inputs sampled at the previous rising clock edge.
- R4: `ctrl[0]` sets polarity. A value of 0 gives an active-high output. A value of 1 inverts the active value, and 1 is then also the inactive level.
- R5: When `hStart`, `hDur`, `vStart` and `vDur` are all zero, the internal pulse is held at 0. The output is then a constant inactive level equal to `ctrl[0]`.
- R6: When `ctrl[1]` = 1 (toggle mode), the channel's own signal is a toggle state. The state flips on each rising edge of the internal pulse and is kept across frames. Reset clears it to 0. The state does not change while `ctrl[1]` = 0.
- R7: In toggle mode, an odd `vDur` with one pulse per line makes the output level at the start of each frame differ from the level at the start of the previous frame.
- R8: `ctrl[4:3]` selects how this channel combines with `prevOut`, before polarity is applied. A value of 00 uses the own signal alone, 01 uses own AND `prevOut`, and 10 uses own OR `prevOut`.
- R9: When `ctrl[4:3]` = 11, a frame flag chooses the source. The flag is cleared by reset and flips in every cycle where `frameStart` = 1. When the updated flag is 1, the output uses `prevOut`; when it is 0, it uses the own signal.
- R10: While `cfgDone` = 0, the output sits at the inactive level and the frame-start count is cleared. Once `cfgDone` = 1, the output becomes active from the cycle of the (`ctrl[6:5]` + 1)-th `frameStart` onward.
- R11: During reset, `gpoOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lineCnt | input | CNT_W | Current line number |
| pixCnt | input | CNT_W | Current pixel position within the line |
| frameStart | input | 1 | One-cycle strobe at the start of each frame |
| cfgDone | input | 1 | High once the timing values and control byte are loaded |
| prevOut | input | 1 | Output of the neighbouring lower channel (0 for the first channel) |
| hStart | input | CNT_W | First pixel of the horizontal span |
| hDur | input | CNT_W | Length of the horizontal span in pixels (0 means always on) |
| vStart | input | CNT_W | First line of the vertical span |
| vDur | input | CNT_W | Length of the vertical span in lines (0 means always on) |
| ctrl | input | 8 | Bit 0 polarity, bit 1 toggle, bits 4:3 combine mode, bits 6:5 activation delay; bits 2 and 7 are not used here |
| gpoOut | output | 1 | Control output |

## Verification
The bench builds the channel with `CNT_W` = 6 and sweeps frames of 12 lines by 64 pixels. Every pixel value the counter can hold is therefore visited, including windows whose start plus duration runs past the counter's top. A cycle-by-cycle arithmetic model checks every clock in scenarios that cover each combine mode, both polarities, toggle mode with odd and even line counts, and each activation delay setting. Frames are short enough that multi-frame effects, such as reversal alternation and frame-alternating selection, appear within a few thousand cycles.

// File: rtl/gpo_chan_pkg.sv
package gpo_chan_pkg;

  typedef enum logic [1:0] {
    MIX_OWN = 2'b00,
    MIX_AND = 2'b01,
    MIX_OR  = 2'b10,
    MIX_ALT = 2'b11
  } mix_e;

  // strobes from the timing control to the output datapath
  typedef struct packed {
    logic gated;    // window intersection this cycle
    logic rise;     // first cycle of a new pulse
    logic usePrev;  // frame-alternation selects neighbour
    logic enable;   // activation delay elapsed
  } strobes_t;

endpackage

// File: rtl/gpo_span.sv
module gpo_span #(
  parameter int W = 11
) (
  input  logic [W-1:0] pos,
  input  logic [W-1:0] start,
  input  logic [W-1:0] len,
  output logic         inWin
);
  localparam int SW = W + 1;

  logic [SW-1:0] stop;

  always_comb begin
    stop  = {1'b0, start} + {1'b0, len};
    inWin = (len == '0) || ((pos >= start) && ({1'b0, pos} < stop));
  end
endmodule

// File: rtl/gpo_timing_ctrl.sv
module gpo_timing_ctrl
  import gpo_chan_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int MAX_DLY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] lineCnt,
  input  logic [CNT_W-1:0] pixCnt,
  input  logic             frameStart,
  input  logic             cfgDone,
  input  logic [CNT_W-1:0] hStart,
  input  logic [CNT_W-1:0] hDur,
  input  logic [CNT_W-1:0] vStart,
  input  logic [CNT_W-1:0] vDur,
  input  logic [1:0]       delaySel,
  output strobes_t         st
);
  localparam int DW = $clog2(MAX_DLY + 1);
  localparam int AXES = 2;

  logic [CNT_W-1:0] posArr   [AXES];
  logic [CNT_W-1:0] startArr [AXES];
  logic [CNT_W-1:0] lenArr   [AXES];
  logic [AXES-1:0]  winHit;

  always_comb begin
    posArr[0] = pixCnt;  startArr[0] = hStart; lenArr[0] = hDur;
    posArr[1] = lineCnt; startArr[1] = vStart; lenArr[1] = vDur;
  end

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    gpo_span #(.W(CNT_W)) u_span (
      .pos  (posArr[a]),
      .start(startArr[a]),
      .len  (lenArr[a]),
      .inWin(winHit[a])
    );
  end

  logic          allZero;
  logic          gatedQ;
  logic          altQ, altN;
  logic [DW-1:0] vsCnt, vsCntN;

  always_comb begin
    allZero = (hStart == '0) && (hDur == '0) && (vStart == '0) && (vDur == '0);
    st.gated = !allZero && (&winHit);
    st.rise  = st.gated && !gatedQ;
    altN     = altQ ^ frameStart;
    st.usePrev = altN;
    if (!cfgDone)
      vsCntN = '0;
    else if (frameStart && (vsCnt != DW'(MAX_DLY)))
      vsCntN = vsCnt + 1'b1;
    else
      vsCntN = vsCnt;
    st.enable = cfgDone && (vsCntN > DW'(delaySel));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gatedQ <= 1'b0;
      altQ   <= 1'b0;
      vsCnt  <= '0;
    end else begin
      gatedQ <= st.gated;
      altQ   <= altN;
      vsCnt  <= vsCntN;
    end
  end
endmodule

// File: rtl/gpo_out_path.sv
module gpo_out_path
  import gpo_chan_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  strobes_t st,
  input  logic     toggleEn,
  input  logic     invert,
  input  mix_e     mixSel,
  input  logic     prevOut,
  output logic     gpoOut
);
  logic tglQ, tglN;
  logic own, mixed, outN;

  always_comb begin
    tglN = tglQ ^ (st.rise && toggleEn);
    own  = toggleEn ? tglN : st.gated;
    unique case (mixSel)
      MIX_OWN: mixed = own;
      MIX_AND: mixed = own & prevOut;
      MIX_OR:  mixed = own | prevOut;
      MIX_ALT: mixed = st.usePrev ? prevOut : own;
      default: mixed = own;
    endcase
    outN = st.enable ? (mixed ^ invert) : invert;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tglQ   <= 1'b0;
      gpoOut <= 1'b0;
    end else begin
      tglQ   <= tglN;
      gpoOut <= outN;
    end
  end
endmodule

// File: rtl/gpo_chan.sv
module gpo_chan
  import gpo_chan_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] lineCnt,
  input  logic [CNT_W-1:0] pixCnt,
  input  logic             frameStart,
  input  logic             cfgDone,
  input  logic             prevOut,
  input  logic [CNT_W-1:0] hStart,
  input  logic [CNT_W-1:0] hDur,
  input  logic [CNT_W-1:0] vStart,
  input  logic [CNT_W-1:0] vDur,
  input  logic [7:0]       ctrl,
  output logic             gpoOut
);
  strobes_t st;
  logic     unusedCtrl;

  assign unusedCtrl = ^{ctrl[7], ctrl[2]};

  gpo_timing_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .lineCnt   (lineCnt),
    .pixCnt    (pixCnt),
    .frameStart(frameStart),
    .cfgDone   (cfgDone),
    .hStart    (hStart),
    .hDur      (hDur),
    .vStart    (vStart),
    .vDur      (vDur),
    .delaySel  (ctrl[6:5]),
    .st        (st)
  );

  gpo_out_path u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .toggleEn(ctrl[1]),
    .invert  (ctrl[0]),
    .mixSel  (mix_e'(ctrl[4:3])),
    .prevOut (prevOut),
    .gpoOut  (gpoOut)
  );
endmodule

// File: rtl/gpo_chan_chk.sv
module gpo_chan_chk
  import gpo_chan_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frameStart,
  input logic             cfgDone,
  input logic             prevOut,
  input logic [CNT_W-1:0] hStart,
  input logic [CNT_W-1:0] hDur,
  input logic [CNT_W-1:0] vStart,
  input logic [CNT_W-1:0] vDur,
  input logic [4:0]       ctrlLo,
  input strobes_t         st,
  input logic             gpoOut
);
  // R10
  hold_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgDone |=> gpoOut == $past(ctrlLo[0]));

  // R10
  enable_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st.enable) |-> frameStart);

  // R5
  all_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hStart == '0 && hDur == '0 && vStart == '0 && vDur == '0 &&
     !ctrlLo[1] && ctrlLo[4:3] == 2'b00) |=> gpoOut == $past(ctrlLo[0]));

  // R6
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st.enable && $past(st.enable) && ctrlLo[1] && ctrlLo[4:3] == 2'b00 &&
     $stable(ctrlLo)) |=> ((gpoOut != $past(gpoOut)) == $past(st.rise)));

  // R8
  and_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st.enable && ctrlLo[4:3] == 2'b01 && !ctrlLo[0] && !prevOut) |=> !gpoOut);

  // R8
  or_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st.enable && ctrlLo[4:3] == 2'b10 && !ctrlLo[0] && prevOut) |=> gpoOut);
endmodule

bind gpo_chan gpo_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .frameStart(frameStart),
  .cfgDone   (cfgDone),
  .prevOut   (prevOut),
  .hStart    (hStart),
  .hDur      (hDur),
  .vStart    (vStart),
  .vDur      (vDur),
  .ctrlLo    (ctrl[4:0]),
  .st        (st),
  .gpoOut    (gpoOut)
);

// File: tb/tb_gpo_chan.sv
module tb_gpo_chan;
  localparam int CNT_W = 6;
  localparam int NP = 64;
  localparam int NL = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0] lineCnt = '0, pixCnt = '0;
  logic frameStart = 1'b0, cfgDone = 1'b0, prevOut = 1'b0;
  logic [CNT_W-1:0] hStart = '0, hDur = '0, vStart = '0, vDur = '0;
  logic [7:0] ctrl = '0;
  logic gpoOut;

  int nRun = 0, nFail = 0;
  bit mG = 0, mTgl = 0, mAlt = 0;
  int mCnt = 0;
  bit frameHead [8];

  always #2 clk = ~clk;

  gpo_chan #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .lineCnt(lineCnt), .pixCnt(pixCnt),
    .frameStart(frameStart), .cfgDone(cfgDone), .prevOut(prevOut),
    .hStart(hStart), .hDur(hDur), .vStart(vStart), .vDur(vDur),
    .ctrl(ctrl), .gpoOut(gpoOut)
  );

  task automatic check(input string req, input bit act, input bit exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s line=%0d pix=%0d ctrl=%h actual=%0b expected=%0b",
               req, lineCnt, pixCnt, ctrl, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  // arithmetic model of one clock, then compare at the next falling edge
  task automatic step(input string req);
    int p = int'(pixCnt);
    int l = int'(lineCnt);
    bit hw, vw, g, rise, own, comb, en, exp;
    hw = (hDur == 0) || (p >= int'(hStart) && p < int'(hStart) + int'(hDur));
    vw = (vDur == 0) || (l >= int'(vStart) && l < int'(vStart) + int'(vDur));
    g = !(hStart == 0 && hDur == 0 && vStart == 0 && vDur == 0) && hw && vw;
    rise = g && !mG;
    mG = g;
    if (rise && ctrl[1]) mTgl = !mTgl;
    if (frameStart) mAlt = !mAlt;
    if (!cfgDone) mCnt = 0;
    else if (frameStart && mCnt < 4) mCnt++;
    en = cfgDone && (mCnt > int'(ctrl[6:5]));
    own = ctrl[1] ? mTgl : g;
    case (ctrl[4:3])
      2'b00: comb = own;
      2'b01: comb = own & prevOut;
      2'b10: comb = own | prevOut;
      default: comb = mAlt ? prevOut : own;
    endcase
    exp = en ? (comb ^ ctrl[0]) : ctrl[0];
    @(posedge clk);
    @(negedge clk);
    check(req, gpoOut, exp);
  endtask

  task automatic setup(input string req, input int hs, input int hd,
                       input int vs, input int vd, input logic [7:0] c);
    cfgDone = 1'b0;
    frameStart = 1'b0;
    hStart = CNT_W'(hs); hDur = CNT_W'(hd);
    vStart = CNT_W'(vs); vDur = CNT_W'(vd);
    ctrl = c;
    step(req);  // R10: output inactive while not configured
    cfgDone = 1'b1;
  endtask

  task automatic frames(input string req, input int n);
    for (int f = 0; f < n; f++)
      for (int l = 0; l < NL; l++)
        for (int p = 0; p < NP; p++) begin
          lineCnt = CNT_W'(l);
          pixCnt = CNT_W'(p);
          frameStart = (l == 0 && p == 0);
          prevOut = pixCnt[2] ^ lineCnt[0];
          step(req);
          if (l == 0 && p == 0 && f < 8) frameHead[f] = gpoOut;
        end
    frameStart = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R11", gpoOut, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", gpoOut, 1'b0);

    // R1 per-line pulse, then a span running past the counter top
    setup("R1", 10, 5, 0, 0, 8'h00); frames("R1", 2);
    setup("R1", 60, 10, 0, 0, 8'h00); frames("R1", 2);
    // R2 line spans, including one ending past the last line
    setup("R2", 0, 0, 3, 4, 8'h00); frames("R2", 2);
    setup("R2", 0, 0, 9, 10, 8'h00); frames("R2", 1);
    // R3 rectangle
    setup("R3", 7, 20, 5, 6, 8'h00); frames("R3", 2);
    // R4 inverted polarity
    setup("R4", 7, 20, 5, 6, 8'h01); frames("R4", 2);
    // R5 all zero at both polarities
    setup("R5", 0, 0, 0, 0, 8'h00); frames("R5", 1);
    setup("R5", 0, 0, 0, 0, 8'h01); frames("R5", 1);
    // R6 and R7 toggle with odd line count
    setup("R6", 4, 2, 2, 3, 8'h02); frames("R6", 3);
    check("R7", frameHead[1], !frameHead[0]);
    check("R7", frameHead[2], !frameHead[1]);
    // R6 toggle with even line count keeps the frame start level
    setup("R6", 4, 2, 2, 4, 8'h02); frames("R6", 3);
    check("R6", frameHead[2], frameHead[1]);
    // R8 combine modes
    setup("R8", 3, 30, 2, 8, 8'h08); frames("R8", 2);
    setup("R8", 3, 30, 2, 8, 8'h10); frames("R8", 2);
    setup("R8", 3, 30, 2, 8, 8'h09); frames("R8", 1);
    // R9 frame alternation
    setup("R9", 3, 30, 2, 8, 8'h18); frames("R9", 3);
    // R10 activation delays
    for (int s = 0; s < 4; s++) begin
      setup("R10", 5, 9, 1, 6, 8'(s << 5)); frames("R10", s + 2);
      check("R10", frameHead[s], 1'b0);
    end
    summary();
  end
endmodule